// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block turns three memory-mapped 32-bit words into one complete serial-flash command. Software first places a command byte and a 24-bit flash address in the command word and, if the command carries a payload, up to four bytes in the data word. It then writes the control word with a transmit byte count, a receive byte count and the start bit. The engine drops chip select, sends the command byte, the address bytes and the payload bytes on a mode-0 serial link, and then clocks in up to four response bytes into the data word. A busy flag in the control word stays set until the sequence is over.

The transmit count covers the command byte, the address bytes and the payload together. A write-enable therefore needs one byte, a sector erase four, and a full 4-byte page program eight. Two control fields, a serial clock divider select and a size field, keep their value across read-modify-write of the counts and the start bit.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset chip select is high, the serial clock is low, the busy flag is 0 and all three words read as zero.
- R2: Word offsets are 0x0 control, 0x4 command/address and 0x8 data, decoded from bus_addr[3:2]. Control fields: [3:0] transmit count, [7:4] receive count, [8] start (always reads 0), [16] busy (read-only), [18:17] size, [25:24] clock select. The count, size and clock-select fields read back exactly as written.
- R3: A control write with bit 8 set while idle makes busy read 1 from the next clock edge. Busy returns to 0 only at least one cycle after chip select has gone high.
- R4: Transmitted bytes, in order: command bits [7:0], then address bits [31:24], [23:16], [15:8], then data bits [7:0], [15:8], [23:16], [31:24]. Transmission stops after the transmit count. Each byte leaves MSB first.
- R5: After the transmit bytes, the engine clocks in the receive-count bytes. The first lands in data bits [7:0] and each later one in the next higher byte lane. Exactly 8 x (transmit + receive) rising serial clock edges occur per command.
- R6: The serial clock idles low, its period is 2 x (clock select + 1) system clocks, and the output data line does not change while the serial clock is high (mode 0).
- R7: While busy, writes to any of the three words are ignored: no field changes and no second command starts.
- R8: A transmit count of 0 is treated as 1 and one above 8 as 8. A receive count above 4 is treated as 4. The command still completes.
- R9: Chip select falls exactly once per command and stays low for the whole transmit-plus-receive sequence. It is low only while busy, and the serial clock is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A wrong byte index or bit counter shows at the serial pins within the same command. A byte is then sent in the wrong order or with the wrong value, or the count of serial clock edges is wrong, and the response lands in the wrong data lane as soon as busy clears. A stuck or early busy flag can be seen on the next control read: the flag reads 0 right after a start, or clears while chip select is still low. A write that leaks through while busy shows up as a changed readback or a second chip-select fall. The bench drives a behavioural flash responder with random command words, counts and divider settings, and adds directed clamping and busy-write cases.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam logic [3:0] MAX_TX = 4'd8;
  localparam logic [3:0] MAX_RX = 4'd4;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_FINISH} state_t;

  state_t      state_q;
  logic [3:0]  tx_cnt_q, rx_cnt_q;
  logic [1:0]  size_q, clk_sel_q;
  logic        busy_q;
  logic [31:0] opaddr_q, data_q;
  logic        cs_n_q, sck_q;
  logic [1:0]  div_q;
  logic [2:0]  bit_q;
  logic [3:0]  byte_q, tx_len_q, tot_q;
  logic [7:0]  tx_sh_q, rx_sh_q;

  wire [1:0] widx     = bus_addr[3:2];
  wire       start_go = bus_wr && !busy_q && widx == 2'd0 && bus_wdata[8];
  wire [3:0] w_tx     = bus_wdata[3:0];
  wire [3:0] w_rx     = bus_wdata[7:4];
  wire [3:0] tx_eff   = (w_tx == 4'd0) ? 4'd1 : (w_tx > MAX_TX) ? MAX_TX : w_tx;
  wire [3:0] rx_eff   = (w_rx > MAX_RX) ? MAX_RX : w_rx;
  wire [3:0] rx_off   = byte_q - tx_len_q;
  wire [1:0] rx_lane  = rx_off[1:0];
  wire       last_b   = (byte_q + 4'd1) == tot_q;

  function automatic logic [7:0] pick(input logic [3:0] idx, input logic [3:0] txl,
                                      input logic [31:0] oa, input logic [31:0] d);
    if (idx >= txl) return 8'h00;
    case (idx)
      4'd0:    return oa[7:0];
      4'd1:    return oa[31:24];
      4'd2:    return oa[23:16];
      4'd3:    return oa[15:8];
      4'd4:    return d[7:0];
      4'd5:    return d[15:8];
      4'd6:    return d[23:16];
      4'd7:    return d[31:24];
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      tx_cnt_q  <= '0;
      rx_cnt_q  <= '0;
      size_q    <= '0;
      clk_sel_q <= '0;
      busy_q    <= 1'b0;
      opaddr_q  <= '0;
      data_q    <= '0;
      cs_n_q    <= 1'b1;
      sck_q     <= 1'b0;
      div_q     <= '0;
      bit_q     <= '0;
      byte_q    <= '0;
      tx_len_q  <= '0;
      tot_q     <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
    end else begin
      if (bus_wr && !busy_q) begin
        case (widx)
          2'd0: begin
            tx_cnt_q  <= w_tx;
            rx_cnt_q  <= w_rx;
            size_q    <= bus_wdata[18:17];
            clk_sel_q <= bus_wdata[25:24];
          end
          2'd1:    opaddr_q <= bus_wdata;
          2'd2:    data_q   <= bus_wdata;
          default: ;
        endcase
      end
      case (state_q)
        S_IDLE: if (start_go) begin
          busy_q   <= 1'b1;
          cs_n_q   <= 1'b0;
          sck_q    <= 1'b0;
          state_q  <= S_SHIFT;
          tx_len_q <= tx_eff;
          tot_q    <= tx_eff + rx_eff;
          byte_q   <= '0;
          bit_q    <= '0;
          div_q    <= '0;
          tx_sh_q  <= opaddr_q[7:0];
        end
        S_SHIFT: begin
          if (div_q == clk_sel_q) begin
            div_q <= '0;
            if (!sck_q) begin
              sck_q   <= 1'b1;
              rx_sh_q <= {rx_sh_q[6:0], spi_miso};
            end else begin
              sck_q   <= 1'b0;
              bit_q   <= bit_q + 3'd1;
              tx_sh_q <= {tx_sh_q[6:0], 1'b0};
              if (bit_q == 3'd7) begin
                if (byte_q >= tx_len_q) data_q[{rx_lane, 3'b000} +: 8] <= rx_sh_q;
                if (last_b) begin
                  state_q <= S_FINISH;
                  cs_n_q  <= 1'b1;
                end else begin
                  byte_q  <= byte_q + 4'd1;
                  tx_sh_q <= pick(byte_q + 4'd1, tx_len_q, opaddr_q, data_q);
                end
              end
            end
          end else begin
            div_q <= div_q + 2'd1;
          end
        end
        S_FINISH: begin
          busy_q  <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign spi_cs_n = cs_n_q;
  assign spi_sck  = sck_q;
  assign spi_mosi = tx_sh_q[7];

  always_comb begin
    case (widx)
      2'd0:    bus_rdata = {6'd0, clk_sel_q, 5'd0, size_q, busy_q, 7'd0, 1'b0, rx_cnt_q, tx_cnt_q};
      2'd1:    bus_rdata = opaddr_q;
      2'd2:    bus_rdata = data_q;
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

module spi_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        busy,
  input logic [31:0] opaddr,
  input logic        spi_cs_n,
  input logic        spi_sck,
  input logic        spi_mosi
);
  // R3
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_wr && bus_addr[3:2] == 2'd0 && bus_wdata[8]) |=> busy);
  // R3
  busy_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (spi_cs_n && $past(spi_cs_n)));
  // R7
  busy_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr[3:2] == 2'd1) |=> $stable(opaddr));
  // R9
  cs_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
  // R9
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .busy(busy_q), .opaddr(opaddr_q),
  .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;

  int checks = 0, errors = 0;

  spi_cmd_engine u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #5 clk = ~clk;

  // flash responder
  logic [7:0] sbyte [12];
  logic [7:0] cap [12];
  int ecount = 0, cs_falls = 0;
  longint t_r0 = 0, t_r1 = 0;
  assign spi_miso = (ecount < 96) ? sbyte[ecount / 8][7 - (ecount % 8)] : 1'b0;

  always @(negedge spi_cs_n or posedge spi_sck) begin
    if (spi_sck && !spi_cs_n) begin
      cap[ecount / 8][7 - (ecount % 8)] = spi_mosi;
      if (ecount == 0) t_r0 = $time;
      if (ecount == 1) t_r1 = $time;
      ecount = ecount + 1;
    end else if (!spi_cs_n) begin
      ecount = 0;
      cs_falls = cs_falls + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [7:0] exp_tx(input int k, input logic [31:0] oa, input logic [31:0] d);
    if (k == 0) return oa[7:0];
    if (k < 4) return oa[8*(4-k) +: 8];
    return d[8*(k-4) +: 8];
  endfunction

  task automatic run_cmd(input logic [31:0] ctrl, input logic [31:0] oa,
                         input logic [31:0] d, input bit poke);
    int tx_e, rx_e, f0, n;
    logic [31:0] r;
    logic [7:0] resp [4];
    bit ok;
    tx_e = (ctrl[3:0] == 0) ? 1 : (ctrl[3:0] > 8) ? 8 : int'(ctrl[3:0]);
    rx_e = (ctrl[7:4] > 4) ? 4 : int'(ctrl[7:4]);
    for (int i = 0; i < 12; i++) sbyte[i] = 8'($urandom);
    for (int j = 0; j < 4; j++) resp[j] = sbyte[tx_e + j];
    wr(4'h4, oa);
    wr(4'h8, d);
    f0 = cs_falls;
    wr(4'h0, ctrl | 32'h100);
    rd(4'h0, r);
    chk(r[16] == 1'b1, "R3 busy after start", longint'(r[16]), 1);
    if (poke) begin
      wr(4'h4, ~oa);
      wr(4'h8, ~d);
      wr(4'h0, 32'h0106_0122);
    end
    n = 0;
    do begin rd(4'h0, r); n++; end while (r[16] && n < 5000);
    repeat (20) @(negedge clk);
    chk(cs_falls == f0 + 1, poke ? "R7 single command" : "R9 one cs fall", cs_falls - f0, 1);
    chk(ecount == 8 * (tx_e + rx_e), "R5/R8 edge count", ecount, 8 * (tx_e + rx_e));
    ok = 1;
    for (int k = 0; k < tx_e; k++) if (cap[k] !== exp_tx(k, oa, d)) ok = 0;
    chk(ok, "R4 transmit bytes", longint'(cap[0]), longint'(exp_tx(0, oa, d)));
    chk((t_r1 - t_r0) == 10 * 2 * (int'(ctrl[25:24]) + 1), "R6 sck period",
        (t_r1 - t_r0) / 10, 2 * (int'(ctrl[25:24]) + 1));
    rd(4'h0, r);
    chk(r == (ctrl & 32'h0306_00FF), "R2 control readback", r, ctrl & 32'h0306_00FF);
    rd(4'h4, r);
    chk(r == oa, "R7 command word kept", r, oa);
    rd(4'h8, r);
    if (rx_e == 0) chk(r == d, "R7 data kept", r, d);
    else begin
      ok = 1;
      for (int j = 0; j < rx_e; j++) if (r[8*j +: 8] !== resp[j]) ok = 0;
      chk(ok, "R5 receive lanes", r, {resp[3], resp[2], resp[1], resp[0]});
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2024));
    for (int i = 0; i < 12; i++) sbyte[i] = 0;
    repeat (3) @(negedge clk);
    #1 chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1 pins in reset", {spi_cs_n, spi_sck}, 2'b10);
    rst_n = 1;
    rd(4'h0, r); chk(r == 0, "R1 control zero", r, 0);
    rd(4'h4, r); chk(r == 0, "R1 command zero", r, 0);
    rd(4'h8, r); chk(r == 0, "R1 data zero", r, 0);

    // directed: write enable, status read, erase, page program, signature
    run_cmd(32'h0000_0001, 32'h0000_0006, 32'h1234_5678, 0);
    run_cmd(32'h0000_0011, 32'h0000_0005, 32'h0, 0);
    run_cmd(32'h0102_0004, 32'h00AB_CDD8, 32'h0, 0);
    run_cmd(32'h0304_0008, 32'h1020_3002, 32'hCAFE_F00D, 0);
    run_cmd(32'h0200_0014, 32'h0000_00AB, 32'h0, 0);
    // R8 clamping
    run_cmd(32'h0000_0000, 32'h0000_0077, 32'h0, 0);
    run_cmd(32'h0100_00FF, 32'h8899_AA55, 32'hDEAD_BEEF, 0);
    // R7 writes while busy
    run_cmd(32'h0300_0008, 32'h1111_2202, 32'h3344_5566, 1);
    run_cmd(32'h0000_0024, 32'h7766_5503, 32'h0, 1);

    for (int n = 0; n < 24; n++) begin
      logic [31:0] c;
      c = {6'd0, 2'($urandom), 5'd0, 2'($urandom), 8'd0, 4'($urandom_range(4, 0)),
           4'($urandom_range(8, 1))};
      run_cmd(c, $urandom, $urandom, n % 5 == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule